// File: doc/BRIEF.md
# Request/Wait Read Servant

This block answers reads from a single master on a request-driven bus. The master raises a request line with an address, and the block fetches the addressed word from an internal read-only storage array. The array's latency can differ from one access to the next. A per-access latency input tells the block how many clock cycles the current fetch will take.

If the fetch completes within a fixed access window of `TACC` cycles, the block answers like a plain strobe servant. The data appears on the bus in time and the wait line never moves. If the fetch needs longer than the window, the block raises its wait line at once, inside the window. It drops the wait line in the same cycle that the data becomes valid.

In both cases the word stays on the bus until the master lowers its request. The block then spends one recovery cycle before it accepts the next read.

Top module: `reqwait_servant`

## Requirements
- R1: While reset is active, and after it, until a read is accepted, `svc_wait` is low and `data_out` is zero.
- R2: When the block is ready and `req` is high at a rising clock edge, that edge accepts a read and captures `addr` and `lat`.
- R3: The word returned for address a is (37·a + 91) mod 2^DW, which for DW=8 is (37·a + 91) mod 256.
- R4: The effective latency E is `lat`, except that a `lat` of 0 counts as 1. When E ≤ TACC, `data_out` carries the word from the E-th rising edge after the accepting edge, and `svc_wait` stays low for the whole read.
- R5: When E > TACC, `svc_wait` goes high at the accepting edge and stays high. It goes low at the E-th edge after the accepting edge, which is the same edge that places the word on `data_out`.
- R6: Before the word becomes valid, `data_out` is zero. From that point, as long as `req` stays high, `data_out` holds the word unchanged and `svc_wait` stays low.
- R7: The first rising edge with `req` low after the word is valid clears `data_out` to zero. The block ignores `req` at the following edge, which is the recovery cycle. It accepts a new read no earlier than the edge after that.
- R8: Changes on `addr` and `lat` after the accepting edge do not affect the word returned or the timing of the read in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request from the master |
| addr | input | AW | Word address, captured when a read is accepted |
| lat | input | LW | Fetch latency in cycles for this access, captured when a read is accepted |
| data_out | output | DW | Read data; zero when not valid |
| svc_wait | output | 1 | High while a slow fetch holds the master off |

## Verification
The bench builds the block with TACC=3, LW=4, AW=4 and DW=8. With these values every latency from 0 to 15 can be driven. This covers the zero-latency case, both sides of the window edge (3 and 4), and the largest slow fetch. The 16-word address space is small enough that the first and last words are both read. The short window also keeps the recovery-cycle case and the mid-access input changes within a few cycles of each read.

// File: rtl/reqwait_servant.sv
module reqwait_servant #(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int LW   = 4,
  parameter int TACC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] lat,
  output logic [DW-1:0] data_out,
  output logic          svc_wait
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_HOLD, S_REST} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] need_q;
  logic [LW-1:0] cnt;

  wire [LW-1:0] lat_eff = (lat == '0) ? LW'(1) : lat;
  wire          slow_in = int'(lat_eff) > TACC;

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd37 + 32'd91;
    return t[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      need_q   <= '0;
      cnt      <= '0;
      data_out <= '0;
      svc_wait <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          addr_q   <= addr;
          need_q   <= lat_eff;
          cnt      <= LW'(1);
          svc_wait <= slow_in;
          st       <= S_FETCH;
        end
        S_FETCH: if (cnt >= need_q) begin
          data_out <= word_at(addr_q);
          svc_wait <= 1'b0;
          st       <= S_HOLD;
        end else begin
          cnt <= cnt + LW'(1);
        end
        S_HOLD: if (!req) begin
          data_out <= '0;
          st       <= S_REST;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_fast_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && int'(need_q) <= TACC) |-> !svc_wait);

  p_slow_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && int'(need_q) > TACC) |-> svc_wait);

  p_wait_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(svc_wait) |-> (st == S_HOLD && data_out == word_at(addr_q)));

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && $past(st == S_HOLD)) |-> ($stable(data_out) && !svc_wait));

  p_zero_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_HOLD) |-> (data_out == '0));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !req) |=> (st == S_REST));

  p_rest_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REST) |=> (st == S_IDLE && !svc_wait));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |-> (cnt <= need_q && cnt != '0));

endmodule

// File: tb/test_reqwait_servant.sv
module test_reqwait_servant;
  localparam int AW = 4, DW = 8, LW = 4, TACC = 3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] lat  = '0;
  logic [DW-1:0] data_out;
  logic svc_wait;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  reqwait_servant #(.AW(AW), .DW(DW), .LW(LW), .TACC(TACC)) i_reqwait_servant (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .lat(lat),
    .data_out(data_out), .svc_wait(svc_wait));

  function automatic int exp_word(input int a);
    return (37 * a + 91) % 256;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(svc_wait == 1'b0, "R1 wait in reset", svc_wait, 0);
    chk(data_out == '0, "R1 data in reset", data_out, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(svc_wait == 1'b0 && data_out == '0, "R1 idle after reset", data_out, 0);
  endtask

  task automatic t_read(input int a, input int l, input int hold, input bit scramble);
    int e; bit slow; int w;
    e = (l == 0) ? 1 : l;
    slow = e > TACC;
    w = exp_word(a);
    @(negedge clk); addr = AW'(a); lat = LW'(l); req = 1'b1;
    @(posedge clk); #1;
    chk(svc_wait == slow, slow ? "R5 wait at accept" : "R4 no wait at accept", svc_wait, slow);
    chk(data_out == '0, "R6 data zero before valid", data_out, 0);
    if (scramble) begin
      @(negedge clk); addr = ~AW'(a); lat = (l > 2) ? LW'(1) : LW'(15);
    end
    for (int k = 1; k < e; k++) begin
      @(posedge clk); #1;
      chk(svc_wait == slow, slow ? "R5 wait held" : "R4 wait quiet", svc_wait, slow);
      chk(data_out == '0, "R6 data zero while fetching", data_out, 0);
    end
    @(posedge clk); #1;
    chk(data_out == DW'(w), scramble ? "R8 word after input change" : "R3 word value", data_out, w);
    chk(svc_wait == 1'b0, slow ? "R5 wait drops with data" : "R4 wait low with data", svc_wait, 0);
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1;
      chk(data_out == DW'(w) && !svc_wait, "R6 data held", data_out, w);
    end
    @(negedge clk); req = 1'b0;
    @(posedge clk); #1;
    chk(data_out == '0, "R7 data cleared on release", data_out, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_recover();
    @(negedge clk); addr = 4'd6; lat = 4'd5; req = 1'b1;
    @(posedge clk); #1;
    repeat (5) @(posedge clk);
    #1;
    chk(data_out == DW'(exp_word(6)), "R2 word before recovery", data_out, exp_word(6));
    @(negedge clk); req = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); addr = 4'd9; lat = 4'd5; req = 1'b1;
    @(posedge clk); #1;
    chk(svc_wait == 1'b0, "R7 req ignored in recovery", svc_wait, 0);
    @(posedge clk); #1;
    chk(svc_wait == 1'b1, "R7 accepted after recovery", svc_wait, 1);
    repeat (5) @(posedge clk);
    #1;
    chk(data_out == DW'(exp_word(9)), "R7 word after recovery", data_out, exp_word(9));
    @(negedge clk); req = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_read(0, 1, 2, 1'b0);
    t_read(5, 3, 1, 1'b0);
    t_read(15, 0, 3, 1'b0);
    t_read(7, 4, 2, 1'b0);
    t_read(12, 15, 1, 1'b0);
    t_read(3, 6, 1, 1'b1);
    t_read(10, 2, 1, 1'b1);
    t_recover();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule